// File: doc/BRIEF.md
# Timed-Unlock Secure Register Access Gate

This block sits on a simple register bus between software and a set of protected peripheral registers. It offers a small number of channels. Each channel owns a slot address in unprotected space and a programmable physical target address in protected space. A bus access to a slot is redirected to that channel's target through a master port.

In Locked mode, a slot only passes traffic after software has unlocked its channel. To unlock, software writes a key and a channel number to an unlock register. Only one channel can be open at a time. An open channel closes again after one completed access, or when a programmable cycle budget runs out without an access, whichever comes first. An access to a closed channel gets a bus error and sets a sticky flag. Each of the two events (refused access, expiry) can drive an interrupt. In Open mode every slot passes traffic at all times.

Responses are combinational within the request cycle. A requester holds `s_req` until it sees `s_ack` or `s_err`, then drops it for at least one cycle. The master port uses the same single-request convention: `m_ack` may be returned in the same cycle as `m_req`.

Top module: `sgate_top`

## Requirements
- R1: After reset the gate is in Locked mode with no channel open. The control register (word address 0x00) and the status register (word address 0x03) read 0, and both interrupt outputs are low.
- R2: The target address of channel i is written at word address 0x10+i, and its slot is at word address 0x20+i. A permitted slot access drives `m_req` with `m_addr` equal to that target, and copies `m_we` and `m_wdata` from the request. `s_ack` follows `m_ack`, and `s_rdata` returns `m_rdata`.
- R3: A write to word address 0x02 with bits [31:24] equal to 0xA5 and a channel number below the channel count in the low bits opens that channel. Status then shows bit 3 set and the channel number in bits [8 +: channel-index width].
- R4: An unlock write with a wrong key byte, or with a channel number at or above the channel count, changes no channel state and sets status bit 2.
- R5: In Locked mode, an access to a slot whose channel is not open is answered with `s_err` in the same cycle, with no `s_ack` and no `m_req`, and it sets status bit 0.
- R6: Unlocking a channel while another one is open closes the first one, so that only the newly unlocked channel passes traffic.
- R7: After one completed forwarded access in Locked mode, the channel is closed, and the next access to it is refused.
- R8: With a cycle budget T written at word address 0x01, the channel accepts an access whose clock edge lies within T+1 edges after the edge of the unlock write. If none arrives, it closes on that last edge and sets status bit 1. An access on that last edge wins, and no expiry is flagged.
- R9: With control bit 0 set (Open mode), every slot forwards its accesses, and the accesses close no channel.
- R10: `irq_deny` equals status bit 0 AND control bit 1, and `irq_tmo` equals status bit 1 AND control bit 2.
- R11: Writing 1 to status bits 0, 1 or 2 clears that bit. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Slave request, held until ack or error |
| s_we | input | 1 | Slave write enable |
| s_addr | input | 6 | Slave word address |
| s_wdata | input | 32 | Slave write data |
| s_rdata | output | 32 | Slave read data |
| s_ack | output | 1 | Slave access completed |
| s_err | output | 1 | Slave access refused (bus error) |
| m_req | output | 1 | Forwarded request to the target |
| m_we | output | 1 | Forwarded write enable |
| m_addr | output | 16 | Physical target address |
| m_wdata | output | 32 | Forwarded write data |
| m_rdata | input | 32 | Target read data |
| m_ack | input | 1 | Target access completed |
| irq_deny | output | 1 | Refused-access interrupt |
| irq_tmo | output | 1 | Expiry interrupt |

## Verification
A wrong open-channel register or a wrong open flag shows up at once, on the very next slot access. Such an access gets `s_err` where `s_ack` was expected, or it reaches `m_req` when it should have been refused. A timer that is off by one only shows up at the edge of the budget window. The bench therefore probes the last permitted cycle and the first refused cycle. Flag corruption reaches the interrupt pins in the same cycle as the status bit, and the status read-back reports it one access later.

// File: rtl/sgate_pkg.sv
package sgate_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam logic [7:0] UNLOCK_KEY = 8'hA5;

    typedef enum logic [2:0] {
        K_NONE, K_CTRL, K_TMO, K_UNLK, K_STAT, K_TGT, K_SLOT
    } kind_e;

    typedef struct packed {
        logic ie_tmo;
        logic ie_deny;
        logic open_mode;
    } ctrl_t;

    typedef struct packed {
        logic key;
        logic tmo;
        logic deny;
    } flags_t;

    function automatic kind_e decode(input logic [ADDR_W-1:0] a);
        kind_e k;
        k = K_NONE;
        case (a[5:4])
            2'b00: begin
                case (a[3:0])
                    4'h0: k = K_CTRL;
                    4'h1: k = K_TMO;
                    4'h2: k = K_UNLK;
                    4'h3: k = K_STAT;
                    default: k = K_NONE;
                endcase
            end
            2'b01: k = K_TGT;
            2'b10: k = K_SLOT;
            default: k = K_NONE;
        endcase
        return k;
    endfunction
endpackage

// File: rtl/sgate_regs.sv
module sgate_regs
    import sgate_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TA_W  = 16,
    parameter int TMR_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  kind_e                     kind,
    input  logic [3:0]                idx,
    input  logic [DATA_W-1:0]         wdata,
    input  logic                      set_deny,
    input  logic                      set_tmo,
    input  logic                      set_key,
    output ctrl_t                     ctrl,
    output logic [TMR_W-1:0]          tmo_val,
    output logic [NCH-1:0][TA_W-1:0]  tgt,
    output flags_t                    flags
);
    localparam int IDX_W = 5;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            tmo_val <= '0;
            tgt     <= '0;
        end else if (wr) begin
            if (kind == K_CTRL) ctrl <= wdata[2:0];
            if (kind == K_TMO)  tmo_val <= wdata[TMR_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                if (kind == K_TGT && {1'b0, idx} == IDX_W'(i))
                    tgt[i] <= wdata[TA_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (wr && kind == K_STAT) flags <= flags & ~wdata[2:0];
            if (set_deny) flags.deny <= 1'b1;
            if (set_tmo)  flags.tmo  <= 1'b1;
            if (set_key)  flags.key  <= 1'b1;
        end
    end

    p_deny_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        flags.deny && !(wr && kind == K_STAT && wdata[0]) |=> flags.deny);
    p_tmo_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        flags.tmo && !(wr && kind == K_STAT && wdata[1]) |=> flags.tmo);
endmodule

// File: rtl/sgate_lock.sv
module sgate_lock #(
    parameter int NCH   = 4,
    parameter int TMR_W = 16,
    parameter int CH_W  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             unlock_ok,
    input  logic [CH_W-1:0]  unlock_ch,
    input  logic [TMR_W-1:0] tmo_load,
    input  logic             used,
    output logic             open_v,
    output logic [CH_W-1:0]  open_ch,
    output logic             tmo_evt
);
    logic [TMR_W-1:0] cnt;

    assign tmo_evt = open_v && !unlock_ok && !used && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_v  <= 1'b0;
            open_ch <= '0;
            cnt     <= '0;
        end else if (unlock_ok) begin
            open_v  <= 1'b1;
            open_ch <= unlock_ch;
            cnt     <= tmo_load;
        end else if (open_v) begin
            if (used || cnt == '0) open_v <= 1'b0;
            else                   cnt <= cnt - 1'b1;
        end
    end

    p_unlock_opens_r6: assert property (@(posedge clk) disable iff (rst)
        unlock_ok |=> open_v && open_ch == $past(unlock_ch));
    p_relock_after_use_r7: assert property (@(posedge clk) disable iff (rst)
        used && !unlock_ok |=> !open_v);
    p_expiry_closes_r8: assert property (@(posedge clk) disable iff (rst)
        tmo_evt |=> !open_v);
    p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
        open_v && !unlock_ok && !used && cnt != '0 |=> open_v && cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/sgate_top.sv
module sgate_top
    import sgate_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int TA_W  = 16,
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_req,
    input  logic              s_we,
    input  logic [5:0]        s_addr,
    input  logic [31:0]       s_wdata,
    output logic [31:0]       s_rdata,
    output logic              s_ack,
    output logic              s_err,
    output logic              m_req,
    output logic              m_we,
    output logic [TA_W-1:0]   m_addr,
    output logic [31:0]       m_wdata,
    input  logic [31:0]       m_rdata,
    input  logic              m_ack,
    output logic              irq_deny,
    output logic              irq_tmo
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    kind_e                    kind;
    logic [3:0]               idx;
    logic                     slot_ok, permit, fwd, deny, cfg, unl_wr, key_ok;
    logic [CH_W-1:0]          uch;
    ctrl_t                    ctrl;
    flags_t                   flags;
    logic [TMR_W-1:0]         tmo_val;
    logic [NCH-1:0][TA_W-1:0] tgt;
    logic                     open_v, tmo_evt, used;
    logic [CH_W-1:0]          open_ch;

    assign kind    = decode(s_addr);
    assign idx     = s_addr[3:0];
    assign slot_ok = (kind == K_SLOT) && ({1'b0, idx} < 5'(NCH));
    assign permit  = ctrl.open_mode || (open_v && open_ch == idx[CH_W-1:0]);
    assign fwd     = s_req && slot_ok && permit;
    assign deny    = s_req && slot_ok && !permit;
    assign cfg     = s_req && !slot_ok;
    assign used    = fwd && m_ack && !ctrl.open_mode;

    assign uch     = s_wdata[CH_W-1:0];
    assign unl_wr  = s_req && s_we && kind == K_UNLK;
    assign key_ok  = s_wdata[31:24] == UNLOCK_KEY && s_wdata[CH_W+7:CH_W] == '0 &&
                     ({1'b0, uch} < (CH_W+1)'(NCH));

    assign m_req   = fwd;
    assign m_we    = s_we;
    assign m_addr  = tgt[idx[CH_W-1:0]];
    assign m_wdata = s_wdata;
    assign s_ack   = cfg || (fwd && m_ack);
    assign s_err   = deny;

    assign irq_deny = flags.deny && ctrl.ie_deny;
    assign irq_tmo  = flags.tmo && ctrl.ie_tmo;

    always_comb begin
        s_rdata = '0;
        case (kind)
            K_CTRL: s_rdata[2:0] = ctrl;
            K_TMO:  s_rdata[TMR_W-1:0] = tmo_val;
            K_STAT: begin
                s_rdata[2:0] = flags;
                s_rdata[3]   = open_v;
                if (open_v) s_rdata[8 +: CH_W] = open_ch;
            end
            K_TGT:  if ({1'b0, idx} < 5'(NCH)) s_rdata[TA_W-1:0] = tgt[idx[CH_W-1:0]];
            K_SLOT: if (slot_ok) s_rdata = m_rdata;
            default: s_rdata = '0;
        endcase
    end

    sgate_regs #(.NCH(NCH), .TA_W(TA_W), .TMR_W(TMR_W)) u_regs (
        .clk(clk), .rst(rst),
        .wr(cfg && s_we), .kind(kind), .idx(idx), .wdata(s_wdata),
        .set_deny(deny), .set_tmo(tmo_evt), .set_key(unl_wr && !key_ok),
        .ctrl(ctrl), .tmo_val(tmo_val), .tgt(tgt), .flags(flags)
    );

    sgate_lock #(.NCH(NCH), .TMR_W(TMR_W), .CH_W(CH_W)) u_lock (
        .clk(clk), .rst(rst),
        .unlock_ok(unl_wr && key_ok), .unlock_ch(uch), .tmo_load(tmo_val),
        .used(used), .open_v(open_v), .open_ch(open_ch), .tmo_evt(tmo_evt)
    );

    p_ack_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(s_ack && s_err));
    p_err_sets_flag_r5: assert property (@(posedge clk) disable iff (rst)
        s_err |=> flags.deny);
    p_err_no_forward_r5: assert property (@(posedge clk) disable iff (rst)
        s_err |-> !m_req);
    p_badkey_keeps_state_r4: assert property (@(posedge clk) disable iff (rst)
        unl_wr && !key_ok && !used && !tmo_evt |=> open_v == $past(open_v) && flags.key);
endmodule

// File: tb/sgate_top_test.sv
module sgate_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        s_req = 1'b0, s_we = 1'b0;
    logic [5:0]  s_addr = '0;
    logic [31:0] s_wdata = '0;
    logic [31:0] s_rdata, m_wdata, m_rdata;
    logic        s_ack, s_err, m_req, m_we, m_ack, irq_deny, irq_tmo;
    logic [15:0] m_addr;

    int total = 0;
    int bad = 0;

    logic [31:0] r_data;
    logic        r_ack, r_err, r_mreq, r_mwe;
    logic [15:0] r_maddr;
    logic [31:0] r_mwdata;

    always #5 clk = ~clk;

    assign m_ack   = m_req;
    assign m_rdata = {16'hD0DE, m_addr};

    sgate_top uut (
        .clk(clk), .rst(rst), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
        .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ack(s_ack), .s_err(s_err),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .irq_deny(irq_deny), .irq_tmo(irq_tmo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus(input logic we, input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        s_req = 1'b1; s_we = we; s_addr = a; s_wdata = d;
        #1;
        r_data = s_rdata; r_ack = s_ack; r_err = s_err;
        r_mreq = m_req; r_mwe = m_we; r_maddr = m_addr; r_mwdata = m_wdata;
        @(negedge clk);
        s_req = 1'b0; s_we = 1'b0;
    endtask

    function automatic logic [15:0] tgt_of(input int i);
        return 16'h1000 + 16'(i) * 16'h0111;
    endfunction

    task automatic t_reset;
        bus(0, 6'h03, 0); chk("R1 status", r_data, 32'h0);
        bus(0, 6'h00, 0); chk("R1 ctrl", r_data, 32'h0);
        chk("R1 irq", {30'b0, irq_deny, irq_tmo}, 32'h0);
    endtask

    task automatic t_setup;
        for (int i = 0; i < 4; i++) bus(1, 6'h10 + 6'(i), {16'h0, tgt_of(i)});
        bus(0, 6'h12, 0); chk("R2 target readback", r_data, {16'h0, tgt_of(2)});
        bus(1, 6'h01, 32'd100);
    endtask

    task automatic t_deny;
        bus(1, 6'h21, 32'h1234);
        chk("R5 err/ack/mreq", {29'b0, r_err, r_ack, r_mreq}, 32'h4);
        bus(0, 6'h03, 0); chk("R5 deny flag", r_data & 32'h1, 32'h1);
        chk("R10 irq off when disabled", {31'b0, irq_deny}, 32'h0);
        bus(1, 6'h03, 32'h0); bus(0, 6'h03, 0);
        chk("R11 write 0 keeps", r_data & 32'h1, 32'h1);
        bus(1, 6'h03, 32'h1); bus(0, 6'h03, 0);
        chk("R11 write 1 clears", r_data & 32'h1, 32'h0);
    endtask

    task automatic t_unlock_fwd;
        bus(1, 6'h02, 32'hA500_0002);
        bus(0, 6'h03, 0); chk("R3 status open ch2", r_data, 32'h0000_0208);
        bus(1, 6'h22, 32'hCAFE_0001);
        chk("R2 ack", {30'b0, r_ack, r_mreq}, 32'h3);
        chk("R2 addr", {16'h0, r_maddr}, {16'h0, tgt_of(2)});
        chk("R2 wdata", r_mwdata, 32'hCAFE_0001);
        chk("R2 we", {31'b0, r_mwe}, 32'h1);
        bus(0, 6'h22, 0);
        chk("R7 second access refused", {30'b0, r_err, r_mreq}, 32'h2);
        bus(0, 6'h03, 0); chk("R7 closed", r_data & 32'h8, 32'h0);
        bus(1, 6'h03, 32'h7);
    endtask

    task automatic t_badkey;
        bus(1, 6'h02, 32'h5A00_0001);
        bus(0, 6'h03, 0); chk("R4 key flag, nothing open", r_data, 32'h4);
        bus(0, 6'h21, 0); chk("R4 slot still locked", {31'b0, r_err}, 32'h1);
        bus(1, 6'h03, 32'h7);
    endtask

    task automatic t_switch;
        bus(1, 6'h02, 32'hA500_0000);
        bus(1, 6'h02, 32'hA500_0003);
        bus(0, 6'h03, 0); chk("R6 status shows ch3", r_data, 32'h0000_0308);
        bus(0, 6'h20, 0); chk("R6 first channel relocked", {31'b0, r_err}, 32'h1);
        bus(0, 6'h23, 0);
        chk("R6 new channel passes", {31'b0, r_ack}, 32'h1);
        chk("R2 read data", r_data, {16'hD0DE, tgt_of(3)});
        bus(1, 6'h03, 32'h7);
    endtask

    task automatic t_timeout;
        bus(1, 6'h01, 32'd3);
        bus(1, 6'h02, 32'hA500_0001);
        repeat (2) @(negedge clk);
        bus(0, 6'h21, 0); chk("R8 last edge accepted", {30'b0, r_ack, r_err}, 32'h2);
        bus(0, 6'h03, 0); chk("R8 no expiry flag", r_data & 32'h2, 32'h0);
        bus(1, 6'h02, 32'hA500_0001);
        repeat (3) @(negedge clk);
        bus(0, 6'h21, 0); chk("R8 one edge late refused", {30'b0, r_ack, r_err}, 32'h1);
        bus(0, 6'h03, 0); chk("R8 expiry flag", r_data & 32'hB, 32'h3);
    endtask

    task automatic t_irq;
        bus(1, 6'h00, 32'h6);
        chk("R10 both irqs", {30'b0, irq_deny, irq_tmo}, 32'h3);
        bus(1, 6'h03, 32'h2);
        chk("R10 tmo irq follows flag", {30'b0, irq_deny, irq_tmo}, 32'h2);
        bus(1, 6'h03, 32'h1);
        chk("R11 irqs cleared", {30'b0, irq_deny, irq_tmo}, 32'h0);
        bus(1, 6'h00, 32'h0);
    endtask

    task automatic t_open;
        bus(1, 6'h00, 32'h1);
        bus(1, 6'h22, 32'h55);
        chk("R9 open first", {30'b0, r_ack, r_err}, 32'h2);
        bus(0, 6'h22, 0);
        chk("R9 open second", {30'b0, r_ack, r_err}, 32'h2);
        bus(0, 6'h20, 0);
        chk("R9 other slot", r_data, {16'hD0DE, tgt_of(0)});
        bus(1, 6'h00, 32'h0);
        bus(0, 6'h22, 0); chk("R9 locked again", {31'b0, r_err}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_setup();
        t_deny();
        t_unlock_fwd();
        t_badkey();
        t_switch();
        t_timeout();
        t_irq();
        t_open();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule